// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block sits between a MAC core's byte-wide transmit path and the two-bit transmit pins of a reduced media independent interface PHY. The MAC offers bytes over a valid/ready handshake. It marks the opening byte of a frame with a start flag and the closing byte with an end flag. The block breaks each byte into four two-bit groups (dibits) and drives them onto the data pins. It raises the transmit enable for exactly as long as frame data is on the wire.

All logic runs on the single 50 MHz reference clock. A static rate input selects the line rate. At 100 Mbps one dibit is presented per clock. At 10 Mbps each dibit is held for ten clocks. The block pulls the next byte exactly when the current one is used up, so bytes within a frame leave with no gap. If the MAC has no byte ready at that moment, the frame is cut short and an error pulse is raised. Preamble, CRC and collision handling belong to other blocks.

Top module: `rmii_tx_serializer`

## Requirements
- R1: Each byte is sent as four dibits on `txd`, in the order bits [1:0], [3:2], [5:4], [7:6]. `txd[0]` carries the lower bit of each pair.
- R2: With `speed_10` low, a new dibit appears on every clock while `txen` is high.
- R3: With `speed_10` high, every dibit stays on `txd` for exactly ten consecutive clocks.
- R4: `txen` rises in the clock after a byte with `in_sof` high is accepted while idle. It falls in the clock after the last dibit of the byte that carried `in_eof`.
- R5: `txd` is 2'b00 whenever `txen` is low.
- R6: `in_ready` is high only in two cases: while idle, and in the final clock of a byte's last dibit when that byte did not carry `in_eof`. Bytes offered in those clocks leave with no idle clock between them.
- R7: Suppose `in_ready` is high mid-frame and `in_valid` is low. Then in the next clock `txen` is low and `underrun` is high for exactly one clock, and the frame is abandoned.
- R8: A byte offered while idle with `in_sof` low is discarded, and `txen` stays low.
- R9: Dropping `in_valid` or changing `in_data` while `in_ready` is low has no effect on the transmitted stream.
- R10: During reset and right after it, `txen`, `txd` and `underrun` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_10 | input | 1 | 1 selects 10 Mbps pacing, 0 selects 100 Mbps; changed only while idle |
| in_valid | input | 1 | MAC byte offered |
| in_data | input | 8 | MAC byte |
| in_sof | input | 1 | Offered byte opens a frame |
| in_eof | input | 1 | Offered byte closes a frame |
| in_ready | output | 1 | Block takes the offered byte at the next edge |
| txen | output | 1 | Transmit enable to the PHY |
| txd | output | 2 | Transmit dibit to the PHY |
| underrun | output | 1 | One-clock pulse when the MAC failed to supply a byte in time |

## Verification
The hardest case to reach is the underrun. The source has to withhold a byte in the one clock where `in_ready` is high inside a frame, and that clock moves with the rate and the byte position. The bench driver does not plan the stall ahead of time. It watches `in_ready` each cycle and lowers `in_valid` only once a chosen byte index is due, at both rates. It also toggles `in_valid` during clocks where `in_ready` is low, to show those clocks are ignored. Back-to-back frames with no idle gap exercise the rising and falling edges of `txen`.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/rmii_tx_pace.sv
// Emits one step per dibit slot: every clock at full rate, every SLOW_DIV clocks slow.
module rmii_tx_pace #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic step
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(SLOW_DIV - 1));
  assign step   = run && (!slow || at_end);

  always_ff @(posedge clk) begin
    if (rst || !run || step) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rmii_tx_shift.sv
// Holds the current byte and presents its low dibit; shifts toward the LSB on advance.
module rmii_tx_shift #(
  parameter int BYTE_W  = 8,
  parameter int DIBIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               advance,
  input  logic               clear,
  input  logic [BYTE_W-1:0]  din,
  output logic [DIBIT_W-1:0] dibit,
  output logic               last
);
  localparam int SLOTS = BYTE_W / DIBIT_W;
  localparam int IW    = (SLOTS > 2) ? $clog2(SLOTS) : 1;

  logic [BYTE_W-1:0] sh;
  logic [IW-1:0]     idx;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= din;
      idx <= '0;
    end else if (advance) begin
      sh  <= sh >> DIBIT_W;
      idx <= idx + 1'b1;
    end
  end

  assign dibit = sh[DIBIT_W-1:0];
  assign last  = (idx == IW'(SLOTS - 1));
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int DIBIT_W  = 2,
  parameter int SLOW_DIV = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               speed_10,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  output logic               in_ready,
  output logic               txen,
  output logic [DIBIT_W-1:0] txd,
  output logic               underrun
);
  tx_state_e state;
  logic      last_byte;
  logic      underrun_q;
  logic      sending, step, last_dibit, boundary;
  logic      take, start, chain, load, finish, starve, advance;

  assign sending  = (state == TX_SEND);
  assign boundary = sending && step && last_dibit;
  assign in_ready = !sending || (boundary && !last_byte);
  assign take     = in_ready && in_valid;
  assign start    = !sending && take && in_sof;
  assign chain    = sending && take;
  assign load     = start || chain;
  assign finish   = boundary && last_byte;
  assign starve   = boundary && !last_byte && !in_valid;
  assign advance  = sending && step && !last_dibit;

  rmii_tx_pace #(.SLOW_DIV(SLOW_DIV)) pace_i (
    .clk  (clk),
    .rst  (rst),
    .run  (sending),
    .slow (speed_10),
    .step (step)
  );

  rmii_tx_shift #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) shift_i (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .advance (advance),
    .clear   (finish || starve),
    .din     (in_data),
    .dibit   (txd),
    .last    (last_dibit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      last_byte  <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= starve;
      if (load) begin
        state     <= TX_SEND;
        last_byte <= in_eof;
      end else if (finish || starve) begin
        state     <= TX_IDLE;
        last_byte <= 1'b0;
      end
    end
  end

  assign txen     = sending;
  assign underrun = underrun_q;
endmodule

// File: rtl/rmii_tx_serializer_chk.sv
module rmii_tx_serializer_chk #(
  parameter int BYTE_W  = 8,
  parameter int DIBIT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               speed_10,
  input logic               in_valid,
  input logic [BYTE_W-1:0]  in_data,
  input logic               in_sof,
  input logic               in_eof,
  input logic               in_ready,
  input logic               txen,
  input logic [DIBIT_W-1:0] txd,
  input logic               underrun
);
  // R5
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !txen |-> (txd == '0));

  // R7
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  // R7
  underrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (!txen && $past(txen)));

  // R4
  txen_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txen) |-> $past(in_valid && in_sof && in_ready));

  // R6
  gapless_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (txen && in_ready && in_valid) |=> txen);

  // R6
  ready_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    (txen && in_ready) |=> (txen || underrun));
endmodule

bind rmii_tx_serializer rmii_tx_serializer_chk #(.BYTE_W(BYTE_W), .DIBIT_W(DIBIT_W)) chk_i (.*);

// File: tb/rmii_tx_serializer_tb_top.sv
module rmii_tx_serializer_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int SLOW_DIV   = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_10 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_ready, txen, underrun;
  logic [1:0] txd;

  rmii_tx_serializer #(.SLOW_DIV(SLOW_DIV)) dut_i (
    .clk(clk), .rst(rst), .speed_10(speed_10), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
    .txen(txen), .txd(txd), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  bit         running = 1'b0;
  logic [3:0] expq[$];   // {txen, txd[1:0], underrun} per cycle
  logic [3:0] exp_now;
  logic       ready_exp;
  logic [7:0] fr[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  // Reference comparison on every clock, sampled at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired (no requirement) actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (running) begin
      exp_now   = (expq.size() != 0) ? expq.pop_front() : 4'b0000;
      ready_exp = (expq.size() == 0);
      check(txen == exp_now[3], "R4 txen", txen, exp_now[3]);
      if (!exp_now[3])
        check(txd == 2'b00, "R5 txd idle", txd, 0);
      else
        check(txd == exp_now[2:1], speed_10 ? "R1 R3 txd" : "R1 R2 txd", txd, exp_now[2:1]);
      check(underrun == exp_now[0], "R7 underrun", underrun, exp_now[0]);
      check(in_ready == ready_exp, "R6 in_ready", in_ready, ready_exp);
    end
  end

  function automatic void push_byte(input logic [7:0] b);
    int hold = speed_10 ? SLOW_DIV : 1;
    for (int k = 0; k < 4; k++)
      for (int h = 0; h < hold; h++)
        expq.push_back({1'b1, b[2*k +: 2], 1'b0});
  endfunction

  // Sends fr; abort_at >= 1 withholds that byte to force an underrun; shy drops valid while not ready (R9).
  task automatic send_frame(input int abort_at, input bit shy);
    int i = 0;
    while (1) begin
      @(negedge clk); #1;
      if (i >= fr.size()) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        break;
      end
      if (i == abort_at && i > 0) begin
        in_valid = 1'b0;
        if (in_ready) begin
          expq.push_back(4'b0001);
          break;
        end
      end else if (shy && !in_ready) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data  = ~fr[i];   // R9: junk while not ready
      end else begin
        in_valid = 1'b1;
        in_data  = fr[i];
        in_sof   = (i == 0);
        in_eof   = (i == fr.size() - 1);
        if (in_ready) begin
          push_byte(fr[i]);
          if (in_eof) expq.push_back(4'b0000);
          i++;
        end
      end
    end
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(txen == 1'b0, "R10 txen", txen, 0);
    check(txd == 2'b00, "R10 txd", txd, 0);
    check(underrun == 1'b0, "R10 underrun", underrun, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    #1; rst = 1'b0; running = 1'b1;

    // R1 R2: ordering at full rate
    fr = '{8'hE4, 8'h1B, 8'hA5};
    send_frame(-1, 1'b0);
    wait_idle();
    // R9: valid dropped while not ready
    fr = '{8'h3C, 8'hC3, 8'h0F, 8'hF0};
    send_frame(-1, 1'b1);
    wait_idle();
    // R8: stray byte without start flag while idle
    in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 8'hFF;
    @(negedge clk); #1;
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (4) @(negedge clk); #1;
    // R7: underrun at full rate
    fr = '{8'h11, 8'h22, 8'h33, 8'h44};
    send_frame(2, 1'b0);
    wait_idle();
    // R4 R6: back-to-back frames, single-byte frame
    fr = '{8'h81};
    send_frame(-1, 1'b0);
    fr = '{8'h7E, 8'hC6};
    send_frame(-1, 1'b0);
    wait_idle();

    // R3: slow rate
    speed_10 = 1'b1;
    fr = '{8'hE4, 8'h5A};
    send_frame(-1, 1'b1);
    wait_idle();
    // R7: underrun at slow rate
    fr = '{8'h96, 8'h69};
    send_frame(1, 1'b0);
    wait_idle();
    fr = '{8'h2D};
    send_frame(-1, 1'b0);
    wait_idle();

    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule